// File: doc/BRIEF.md
# Processor Mode and Stack-Select Controller

This block holds the execution context of a small embedded core. The context is the mode (thread or handler), the effective privilege, which of two banked stack pointers is live, and the number of the exception being serviced. The core's sequencer signals exception entry with a number. It signals exception return with the number of the handler being resumed. It also issues writes to a two-bit mode-control word and writes to the stack pointer. The block answers with the live mode, privilege, stack select, stack pointer value and exception number. All of these come straight from registers.

The two-bit control word has two fields. Bit 1 lowers thread code to unprivileged. Bit 0 moves thread code onto the process stack. Handler mode overrides both fields: it always runs privileged and on the main stack. A nesting depth counter records how many exceptions are active. On an exception return, this counter decides whether the core goes back to an outer handler or to thread mode.

Top module: `core_mode_ctrl`

## Requirements
- R1: After reset the block is in thread mode (`handlerMode`=0) and privileged. The control word is 0, the main stack is live and holds `MSP_RESET`, the process stack holds `PSP_RESET`, and `excNum` is 0.
- R2: In thread mode, control bit 0 picks the live stack: 0 selects the main stack and 1 selects the process stack. `activeSp` shows the live one, and `spWrEn` writes only the live one.
- R3: A control write (`ctrlWrEn`) takes effect only while the core is privileged. In thread mode with control bit 1 set, the write is ignored and `ctrlValue` is unchanged.
- R4: An entry strobe with a nonzero number switches to handler mode on the next edge and sets `excNum` to that number. An entry with number 0 is ignored, and so is an entry made while `DEPTH_MAX` exceptions are already active.
- R5: Privilege is always granted in handler mode. In thread mode, privilege is the inverse of control bit 1.
- R6: A return strobe lowers the nesting depth by one. If the depth reaches zero, the block goes to thread mode with `excNum`=0. Otherwise it stays in handler mode with `excNum`=`excRetNum`. A return in thread mode is ignored. An entry strobe in the same cycle blocks the return.
- R7: In handler mode the main stack is live, whatever control bit 0 holds.
- R8: Every stack pointer write clears the two least significant bits.
- R9: A stack pointer write or a control write in the same cycle as any other event is decided on the mode, privilege and stack select held before that edge.
- R10: An unprivileged thread becomes privileged again only after a handler clears control bit 1 and returns to thread mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| excEnter | input | 1 | Exception entry strobe |
| excEnterNum | input | NUM_W | Number of the exception being entered |
| excReturn | input | 1 | Exception return strobe |
| excRetNum | input | NUM_W | Number of the outer handler resumed by the return |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 2 | Control word data: bit 1 thread unprivileged, bit 0 process stack |
| spWrEn | input | 1 | Stack pointer write strobe |
| spWrData | input | SP_W | Stack pointer write data |
| handlerMode | output | 1 | 1 in handler mode, 0 in thread mode |
| privileged | output | 1 | Effective privilege |
| useProcSp | output | 1 | 1 while the process stack is live |
| activeSp | output | SP_W | Value of the live stack pointer |
| excNum | output | NUM_W | Exception being serviced, 0 in thread mode |
| ctrlValue | output | 2 | Current control word |

## Verification
The bench aims at the cases where the control word and the mode disagree. The first is a handler with control bit 0 set: a design that ignored the override would show and write the process stack inside the handler. The second is a locked thread that tries to clear its own unprivileged bit: a design that failed here would let user code regain privilege. The third is a return from a nested handler: a design with a wrong depth count would drop to thread mode early, or would keep reporting the inner exception number. The bench also targets same-cycle collisions and the full nesting stack. In a collision, a design that used the next-state select would write the wrong stack bank or let a simultaneous return undo an entry. At full depth, a design without the limit would wrap its counter and fall back to thread mode.

// File: rtl/mode_pkg.sv
package mode_pkg;
  localparam int CTRL_SP_BIT   = 0;
  localparam int CTRL_PRIV_BIT = 1;

  typedef struct packed {
    logic enter;
    logic leave;
    logic toThread;
    logic ctrlWr;
    logic spWrMain;
    logic spWrProc;
  } mode_strobe_t;
endpackage

// File: rtl/sp_bank_reg.sv
module sp_bank_reg #(
  parameter int          W          = 32,
  parameter int          ALIGN_BITS = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ALIGN_MASK = ~((W'(1) << ALIGN_BITS) - W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     q <= RESET_VAL & ALIGN_MASK;
    else if (wrEn) q <= wrData & ALIGN_MASK;
  end
endmodule

// File: rtl/mode_seq.sv
module mode_seq import mode_pkg::*; #(
  parameter int NUM_W     = 9,
  parameter int DEPTH_MAX = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excEnter,
  input  logic [NUM_W-1:0] excEnterNum,
  input  logic             excReturn,
  input  logic             ctrlWrEn,
  input  logic             spWrEn,
  input  logic [1:0]       ctrlNow,
  output mode_strobe_t     strb,
  output logic             handlerMode,
  output logic             privileged,
  output logic             useProcSp
);
  localparam int DW = $clog2(DEPTH_MAX + 1);
  localparam logic [DW-1:0] DEPTH_TOP = DW'(DEPTH_MAX);
  localparam logic [DW-1:0] DEPTH_ONE = DW'(1);

  logic [DW-1:0] depth;
  logic          enterOk;
  logic          leaveOk;

  // mode and privilege come from registered state only
  always_comb begin
    handlerMode = (depth != '0);
    privileged  = handlerMode || !ctrlNow[CTRL_PRIV_BIT];
    useProcSp   = !handlerMode && ctrlNow[CTRL_SP_BIT];
  end

  // an entry strobe always blocks a return in the same cycle
  always_comb begin
    enterOk = excEnter && (excEnterNum != '0) && (depth != DEPTH_TOP);
    leaveOk = !excEnter && excReturn && (depth != '0);
  end

  always_comb begin
    strb          = '0;
    strb.enter    = enterOk;
    strb.leave    = leaveOk;
    strb.toThread = leaveOk && (depth == DEPTH_ONE);
    strb.ctrlWr   = ctrlWrEn && privileged;
    strb.spWrMain = spWrEn && !useProcSp;
    strb.spWrProc = spWrEn && useProcSp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        depth <= '0;
    else if (enterOk) depth <= depth + DEPTH_ONE;
    else if (leaveOk) depth <= depth - DEPTH_ONE;
  end
endmodule

// File: rtl/mode_data.sv
module mode_data import mode_pkg::*; #(
  parameter int              SP_W      = 32,
  parameter int              NUM_W     = 9,
  parameter logic [SP_W-1:0] MSP_RESET = '0,
  parameter logic [SP_W-1:0] PSP_RESET = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  mode_strobe_t     strb,
  input  logic [1:0]       ctrlWrData,
  input  logic [SP_W-1:0]  spWrData,
  input  logic [NUM_W-1:0] excEnterNum,
  input  logic [NUM_W-1:0] excRetNum,
  input  logic             useProcSp,
  output logic [1:0]       ctrlValue,
  output logic [NUM_W-1:0] excNum,
  output logic [SP_W-1:0]  activeSp
);
  localparam int BANKS = 2;

  logic [SP_W-1:0] bankQ [BANKS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlValue <= '0;
    else if (strb.ctrlWr) ctrlValue <= ctrlWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           excNum <= '0;
    else if (strb.enter) excNum <= excEnterNum;
    else if (strb.leave) excNum <= strb.toThread ? '0 : excRetNum;
  end

  // bank 0 is the main stack, bank 1 the process stack
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    sp_bank_reg #(
      .W         (SP_W),
      .ALIGN_BITS(2),
      .RESET_VAL (g == 0 ? MSP_RESET : PSP_RESET)
    ) u_bank (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (g == 0 ? strb.spWrMain : strb.spWrProc),
      .wrData(spWrData),
      .q     (bankQ[g])
    );
  end

  assign activeSp = useProcSp ? bankQ[1] : bankQ[0];
endmodule

// File: rtl/core_mode_ctrl.sv
module core_mode_ctrl import mode_pkg::*; #(
  parameter int              SP_W      = 32,
  parameter int              NUM_W     = 9,
  parameter int              DEPTH_MAX = 8,
  parameter logic [SP_W-1:0] MSP_RESET = SP_W'(32'h2000_0400),
  parameter logic [SP_W-1:0] PSP_RESET = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excEnter,
  input  logic [NUM_W-1:0] excEnterNum,
  input  logic             excReturn,
  input  logic [NUM_W-1:0] excRetNum,
  input  logic             ctrlWrEn,
  input  logic [1:0]       ctrlWrData,
  input  logic             spWrEn,
  input  logic [SP_W-1:0]  spWrData,
  output logic             handlerMode,
  output logic             privileged,
  output logic             useProcSp,
  output logic [SP_W-1:0]  activeSp,
  output logic [NUM_W-1:0] excNum,
  output logic [1:0]       ctrlValue
);
  mode_strobe_t strb;

  mode_seq #(.NUM_W(NUM_W), .DEPTH_MAX(DEPTH_MAX)) u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .excEnter   (excEnter),
    .excEnterNum(excEnterNum),
    .excReturn  (excReturn),
    .ctrlWrEn   (ctrlWrEn),
    .spWrEn     (spWrEn),
    .ctrlNow    (ctrlValue),
    .strb       (strb),
    .handlerMode(handlerMode),
    .privileged (privileged),
    .useProcSp  (useProcSp)
  );

  mode_data #(
    .SP_W(SP_W), .NUM_W(NUM_W), .MSP_RESET(MSP_RESET), .PSP_RESET(PSP_RESET)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ctrlWrData (ctrlWrData),
    .spWrData   (spWrData),
    .excEnterNum(excEnterNum),
    .excRetNum  (excRetNum),
    .useProcSp  (useProcSp),
    .ctrlValue  (ctrlValue),
    .excNum     (excNum),
    .activeSp   (activeSp)
  );
endmodule

// File: rtl/mode_ctrl_chk.sv
module mode_ctrl_chk #(
  parameter int SP_W  = 32,
  parameter int NUM_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             excEnter,
  input logic [NUM_W-1:0] excEnterNum,
  input logic             excReturn,
  input logic             handlerMode,
  input logic             privileged,
  input logic             useProcSp,
  input logic [SP_W-1:0]  activeSp,
  input logic [NUM_W-1:0] excNum,
  input logic [1:0]       ctrlValue
);
  a_r5_handler_priv: assert property (@(posedge clk) disable iff (!rstN)
    handlerMode |-> privileged);

  a_r7_handler_main_sp: assert property (@(posedge clk) disable iff (!rstN)
    handlerMode |-> !useProcSp);

  a_r6_thread_num_zero: assert property (@(posedge clk) disable iff (!rstN)
    !handlerMode |-> (excNum == '0));

  a_r3_locked_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    !privileged |=> (ctrlValue == $past(ctrlValue)));

  a_r4_entry_from_thread: assert property (@(posedge clk) disable iff (!rstN)
    (excEnter && (excEnterNum != '0) && !handlerMode)
      |=> (handlerMode && (excNum == $past(excEnterNum))));

  a_r6_return_in_thread: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !excEnter && !handlerMode) |=> !handlerMode);

  a_r8_sp_aligned: assert property (@(posedge clk) disable iff (!rstN)
    activeSp[1:0] == 2'b00);
endmodule

bind core_mode_ctrl mode_ctrl_chk #(.SP_W(SP_W), .NUM_W(NUM_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .excEnter   (excEnter),
  .excEnterNum(excEnterNum),
  .excReturn  (excReturn),
  .handlerMode(handlerMode),
  .privileged (privileged),
  .useProcSp  (useProcSp),
  .activeSp   (activeSp),
  .excNum     (excNum),
  .ctrlValue  (ctrlValue)
);

// File: tb/sim_core_mode_ctrl.sv
`timescale 1ns/1ps
module sim_core_mode_ctrl;
  localparam int          SP_W      = 32;
  localparam int          NUM_W     = 9;
  localparam int          DEPTH_MAX = 8;
  localparam logic [31:0] MSP_INIT  = 32'h2000_0400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excEnter = 1'b0, excReturn = 1'b0, ctrlWrEn = 1'b0, spWrEn = 1'b0;
  logic [NUM_W-1:0] excEnterNum = '0, excRetNum = '0;
  logic [1:0] ctrlWrData = '0;
  logic [SP_W-1:0] spWrData = '0;
  logic handlerMode, privileged, useProcSp;
  logic [SP_W-1:0] activeSp;
  logic [NUM_W-1:0] excNum;
  logic [1:0] ctrlValue;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  core_mode_ctrl #(.SP_W(SP_W), .NUM_W(NUM_W), .DEPTH_MAX(DEPTH_MAX),
                   .MSP_RESET(MSP_INIT), .PSP_RESET('0)) u0 (
    .clk(clk), .rstN(rstN),
    .excEnter(excEnter), .excEnterNum(excEnterNum),
    .excReturn(excReturn), .excRetNum(excRetNum),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .spWrEn(spWrEn), .spWrData(spWrData),
    .handlerMode(handlerMode), .privileged(privileged), .useProcSp(useProcSp),
    .activeSp(activeSp), .excNum(excNum), .ctrlValue(ctrlValue)
  );

  // behavioural reference: a queue of active exception numbers
  int unsigned mMain, mProc;
  int unsigned mCtrl;
  int unsigned mStk[$];

  function automatic bit mHandler();
    return mStk.size() > 0;
  endfunction
  function automatic bit mPriv();
    return mHandler() || (mCtrl[1] == 1'b0);
  endfunction
  function automatic bit mProcSel();
    return !mHandler() && (mCtrl[0] == 1'b1);
  endfunction
  function automatic int unsigned mNum();
    return mHandler() ? mStk[mStk.size()-1] : 0;
  endfunction
  function automatic int unsigned mSp();
    return mProcSel() ? mProc : mMain;
  endfunction
  function automatic int unsigned mOuter();
    return (mStk.size() >= 2) ? mStk[mStk.size()-2] : 0;
  endfunction

  always @(posedge clk) begin : model
    bit wasProc, wasPriv;
    if (!rstN) begin
      mMain = MSP_INIT; mProc = 0; mCtrl = 0; mStk.delete();
    end else begin
      wasProc = mProcSel();
      wasPriv = mPriv();
      if (spWrEn) begin
        if (wasProc) mProc = spWrData & 32'hFFFF_FFFC;
        else         mMain = spWrData & 32'hFFFF_FFFC;
      end
      if (ctrlWrEn && wasPriv) mCtrl = ctrlWrData;
      if (excEnter) begin
        if (excEnterNum != 0 && mStk.size() < DEPTH_MAX) mStk.push_back(excEnterNum);
      end else if (excReturn && mStk.size() > 0) begin
        void'(mStk.pop_back());
      end
    end
  end

  task automatic cmp(string req, int unsigned got, int unsigned exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      cmp("R4 handlerMode", handlerMode, mHandler());
      cmp("R5 privileged", privileged, mPriv());
      cmp("R7 useProcSp", useProcSp, mProcSel());
      cmp("R2 activeSp", activeSp, mSp());
      cmp("R6 excNum", excNum, mNum());
      cmp("R3 ctrlValue", ctrlValue, mCtrl);
    end
  end

  task automatic clearIn();
    excEnter = 0; excReturn = 0; ctrlWrEn = 0; spWrEn = 0;
  endtask
  task automatic tick();
    @(negedge clk);
    clearIn();
  endtask
  task automatic doEnter(int unsigned n);
    excEnter = 1; excEnterNum = NUM_W'(n); tick();
  endtask
  task automatic doReturn(int unsigned outer);
    excReturn = 1; excRetNum = NUM_W'(outer); tick();
  endtask
  task automatic doCtrl(int unsigned v);
    ctrlWrEn = 1; ctrlWrData = 2'(v); tick();
  endtask
  task automatic doSp(int unsigned v);
    spWrEn = 1; spWrData = v; tick();
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 mode", handlerMode, 0);
    cmp("R1 priv", privileged, 1);
    cmp("R1 ctrl", ctrlValue, 0);
    cmp("R1 sp", activeSp, MSP_INIT);
    cmp("R1 num", excNum, 0);

    doSp(32'h1003);               cmp("R8 main aligned", activeSp, 32'h1000);
    doCtrl(1);                    cmp("R2 proc selected", useProcSp, 1);
                                  cmp("R2 proc value", activeSp, 0);
    doSp(32'h2007);               cmp("R8 proc aligned", activeSp, 32'h2004);
    doEnter(11);                  cmp("R4 enter", excNum, 11);
                                  cmp("R7 main in handler", activeSp, 32'h1000);
    doCtrl(3);                    cmp("R3 handler write", ctrlValue, 3);
                                  cmp("R5 handler priv", privileged, 1);
                                  cmp("R7 bit0 overridden", useProcSp, 0);
    doEnter(15);                  cmp("R4 nested", excNum, 15);
    doReturn(11);                 cmp("R6 outer num", excNum, 11);
                                  cmp("R6 still handler", handlerMode, 1);
    doReturn(0);                  cmp("R6 to thread", handlerMode, 0);
                                  cmp("R6 num zero", excNum, 0);
                                  cmp("R5 thread unpriv", privileged, 0);
                                  cmp("R2 proc back", activeSp, 32'h2004);
    doCtrl(0);                    cmp("R3 locked ignore", ctrlValue, 3);
    doReturn(0);                  cmp("R6 thread return ignored", handlerMode, 0);
    doEnter(0);                   cmp("R4 zero num ignored", handlerMode, 0);
    doEnter(3);
    doCtrl(0);
    doReturn(0);                  cmp("R10 regained priv", privileged, 1);
                                  cmp("R10 ctrl cleared", ctrlValue, 0);
    // R9: select switch and stack write in one cycle use the old select
    ctrlWrEn = 1; ctrlWrData = 2'd1; spWrEn = 1; spWrData = 32'h3000; tick();
                                  cmp("R9 proc untouched", activeSp, 32'h2004);
    doCtrl(0);                    cmp("R9 main written", activeSp, 32'h3000);
    // R6: entry blocks a simultaneous return
    excEnter = 1; excEnterNum = 9'd5; excReturn = 1; excRetNum = '0; tick();
                                  cmp("R6 entry wins", excNum, 5);
    doReturn(0);                  cmp("R6 back to thread", handlerMode, 0);
    // R4: saturation at DEPTH_MAX
    for (int i = 0; i < DEPTH_MAX; i++) doEnter(20 + i);
                                  cmp("R4 deepest", excNum, 20 + DEPTH_MAX - 1);
    doEnter(40);                  cmp("R4 full ignored", excNum, 20 + DEPTH_MAX - 1);
    for (int i = DEPTH_MAX - 1; i >= 1; i--) doReturn(20 + i - 1);
                                  cmp("R6 outermost", excNum, 20);
    doReturn(0);                  cmp("R6 unwound", handlerMode, 0);

    // random traffic, checked every cycle by the reference
    for (int i = 0; i < 2000; i++) begin
      excEnter    = ($urandom_range(0, 9) < 2);
      excEnterNum = NUM_W'($urandom_range(0, 30));
      excReturn   = ($urandom_range(0, 9) < 3);
      excRetNum   = NUM_W'(mOuter());
      ctrlWrEn    = ($urandom_range(0, 9) < 2);
      ctrlWrData  = 2'($urandom_range(0, 3));
      spWrEn      = ($urandom_range(0, 9) < 3);
      spWrData    = $urandom;
      tick();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule